// File: doc/BRIEF.md
# Free-Running Microsecond Timer with Coherent Split Read

This block is a 12-bit up-counter that advances once for each one-microsecond tick strobe. It rolls over freely, so firmware can time intervals of up to about 4 ms. Firmware reads the count over an 8-bit data path in two steps: first the low byte, then the high nibble.

Reading the low byte copies the upper four counter bits into a holding register. A later read of the high part returns that held copy, not the live counter. The two halves therefore always belong to the same counter value, however many ticks pass between the reads.

Two periodic interrupt pulses are taken from the counter. One fires every 128 ticks (128 µs). The other fires every 1024 ticks (1.024 ms). The tick strobe comes from outside the block, and routing the interrupts onward is left to the surrounding logic.

Top module: `frt_timer`

## Requirements
- R1: After reset the counter, the holding register and both interrupt outputs are zero, so both read selections return 0x00.
- R2: On each clock edge where `tick_i` is high the counter rises by exactly one. When `tick_i` is low the counter keeps its value.
- R3: The counter wraps from 0xFFF to 0x000 and keeps counting.
- R4: With `rd_sel_i` = 0 (low byte), `rd_data_o` shows bits 7:0 of the current counter in the same cycle.
- R5: A cycle with `rd_en_i` = 1 and `rd_sel_i` = 0 stores counter bits 11:8 in the holding register. With `rd_sel_i` = 1 (high part), `rd_data_o[3:0]` shows that stored value and ignores any ticks since the capture.
- R6: With `rd_sel_i` = 1, `rd_data_o[7:4]` is 0. A high-part read (`rd_en_i` = 1, `rd_sel_i` = 1) leaves the holding register unchanged.
- R7: If a low-byte read and a tick fall in the same cycle, the captured nibble is taken from the counter value before that tick is added. This matches the low byte returned in that cycle.
- R8: `irq_128_o` is high for exactly one cycle after each tick that brings counter bits 6:0 to zero, which is once every 128 ticks.
- R9: `irq_1024_o` is high for exactly one cycle after each tick that brings counter bits 9:0 to zero, which is once every 1024 ticks. It is never high unless `irq_128_o` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe, once per microsecond |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 1 | 0 = low byte, 1 = high part |
| rd_data_o | output | 8 | Read data for the selected part |
| irq_128_o | output | 1 | Pulse every 128 ticks |
| irq_1024_o | output | 1 | Pulse every 1024 ticks |

## Verification
The assertions take each read strobe as a single-cycle access: any cycle with `rd_en_i` high and `rd_sel_i` low counts as a new capture. They also take `tick_i` as a plain per-cycle enable that may be high in any cycle, back-to-back included.

The stimulus drives every input once per cycle, away from the clock edge. It sweeps the counter through more than one full wrap, with ticks that are sometimes dense and sometimes sparse. It places low-byte reads in the same cycles as ticks on purpose, and it leaves long gaps between a low read and the matching high read.

// File: rtl/frt_pkg.sv
package frt_pkg;
    typedef enum logic {
        SEL_LOW  = 1'b0,
        SEL_HIGH = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_o == CNT_W'($past(cnt_o) + CNT_W'(1)));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_o));
endmodule

// File: rtl/frt_snapshot.sv
module frt_snapshot #(
    parameter int CNT_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              rd_en_i,
    input  frt_pkg::rd_sel_e  rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o
);
    import frt_pkg::*;

    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        logic [HI_W-1:0] hold;
    } snap_state_t;

    snap_state_t st_d, st_q;
    logic        capture;

    assign capture = rd_en_i && (rd_sel_i == SEL_LOW);

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.hold = cnt_i[CNT_W-1:DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (rd_sel_i == SEL_LOW) begin
            rd_data_o = cnt_i[DATA_W-1:0];
        end else begin
            rd_data_o = {{(DATA_W-HI_W){1'b0}}, st_q.hold};
        end
    end

    // R5 R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(st_q.hold));

    // R7
    capture_pre_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> st_q.hold == $past(cnt_i[CNT_W-1:DATA_W]));
endmodule

// File: rtl/frt_irq_tap.sv
module frt_irq_tap #(
    parameter int TAP_BITS = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic [TAP_BITS-1:0] cnt_low_i,
    output logic                pulse_o
);
    typedef struct packed {
        logic pulse;
    } tap_state_t;

    tap_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = tick_i && (&cnt_low_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    // R8 R9
    pulse_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (cnt_low_i == '0) && $past(tick_i));

    // R8 R9
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/frt_timer.sv
module frt_timer #(
    parameter int CNT_W    = 12,
    parameter int DATA_W   = 8,
    parameter int SHORT_W  = 7,
    parameter int LONG_W   = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rd_en_i,
    input  logic              rd_sel_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_128_o,
    output logic              irq_1024_o
);
    import frt_pkg::*;

    localparam int N_TAPS = 2;

    logic [CNT_W-1:0]  cnt;
    logic [N_TAPS-1:0] pulses;
    rd_sel_e           sel;

    assign sel = rd_sel_e'(rd_sel_i);

    frt_counter #(.CNT_W(CNT_W)) i_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .cnt_o  (cnt)
    );

    frt_snapshot #(.CNT_W(CNT_W), .DATA_W(DATA_W)) i_snapshot (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt),
        .rd_en_i   (rd_en_i),
        .rd_sel_i  (sel),
        .rd_data_o (rd_data_o)
    );

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int TW = (g == 0) ? SHORT_W : LONG_W;
        frt_irq_tap #(.TAP_BITS(TW)) i_tap (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick_i    (tick_i),
            .cnt_low_i (cnt[TW-1:0]),
            .pulse_o   (pulses[g])
        );
    end

    assign irq_128_o  = pulses[0];
    assign irq_1024_o = pulses[1];

    // R9
    long_implies_short_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_1024_o |-> irq_128_o);
endmodule

// File: tb/test_frt_timer.sv
module test_frt_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic       irq_s, irq_l;

    int n_checks = 0;
    int n_fail   = 0;
    logic [11:0] mdl = '0;
    logic [3:0]  mdl_hold = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    frt_timer i_frt_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .rd_en_i    (rd_en),
        .rd_sel_i   (rd_sel),
        .rd_data_o  (rd_data),
        .irq_128_o  (irq_s),
        .irq_1024_o (irq_l)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (model count 0x%0h)", req, act, exp, mdl);
        end
    endtask

    // One cycle: drive at negedge, check read data, then registered outputs after the edge.
    task automatic step(input logic t, input logic en, input logic sel, input string req);
        logic [11:0] nxt;
        logic        es, el;
        @(negedge clk);
        tick = t; rd_en = en; rd_sel = sel;
        #1;
        if (!sel) check({req, " R4 low byte"}, 32'(rd_data), 32'(mdl[7:0]));
        else begin
            check({req, " R5 held nibble"}, 32'(rd_data[3:0]), 32'(mdl_hold));
            check("R6 upper bits zero", 32'(rd_data[7:4]), 32'd0);
        end
        @(posedge clk);
        if (en && !sel) mdl_hold = mdl[11:8];   // R7: pre-increment value
        nxt = t ? mdl + 12'd1 : mdl;
        es = t && (nxt[6:0] == 7'd0);
        el = t && (nxt[9:0] == 10'd0);
        mdl = nxt;
        #1;
        check("R8 irq_128", 32'(irq_s), 32'(es));
        check("R9 irq_1024", 32'(irq_l), 32'(el));
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 150000 && !done; wd++) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 irq_128 reset", 32'(irq_s), 32'd0);
        check("R1 irq_1024 reset", 32'(irq_l), 32'd0);
        rd_sel = 1'b0; #1;
        check("R1 low byte reset", 32'(rd_data), 32'd0);
        rd_sel = 1'b1; #1;
        check("R1 high reset", 32'(rd_data), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 idle cycles hold the count
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, "R2 idle");

        // R2 R3 R8 R9: dense ticks through more than one full wrap, mixed reads
        for (int i = 0; i < 4200; i++) begin
            logic en, sel;
            en  = (i % 5 == 0) || (i % 5 == 2);
            sel = (i % 5 == 2);
            step(1'b1, en, sel, "R2 R3 dense");
        end

        // R7: low read in same cycle as tick, stepping across nibble boundary
        while (mdl[7:0] != 8'hFF) step(1'b1, 1'b0, 1'b0, "R2 align");
        step(1'b1, 1'b1, 1'b0, "R7 same-cycle");
        step(1'b0, 1'b1, 1'b1, "R7 pre-tick nibble");

        // R5 R6: long gap after capture; high reads do not recapture
        step(1'b0, 1'b1, 1'b0, "R5 capture");
        for (int i = 0; i < 2500; i++) begin
            step(1'b1, (i % 97 == 0), 1'b1, "R5 R6 gap");
        end

        // Sparse ticks with occasional captures
        for (int i = 0; i < 6000; i++) begin
            step((i % 3 != 1), (i % 11 == 0), (i % 11 != 0) && (i % 4 == 0), "R2 sparse");
        end

        // R3 explicit wrap
        while (mdl != 12'hFFE) step(1'b1, 1'b0, 1'b0, "R3 approach");
        step(1'b1, 1'b0, 1'b0, "R3 to FFF");
        step(1'b1, 1'b1, 1'b0, "R3 wrap");
        check("R3 wrapped model", 32'(mdl), 32'd0);
        step(1'b0, 1'b1, 1'b1, "R3 hold after wrap");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule